// File: doc/BRIEF.md
# Serial PLL Parameter Receiver

This block listens to a three-wire serial bus (data, bit clock and latch) that it shares with another peripheral, and it never drives any of the three lines. From that bus it picks up a 16-bit word that configures a clock synthesizer. The word holds a 7-bit multiplier, a 7-bit divider and a 2-bit post-divider. A downstream unit derives the synthesized frequency as 31.3344 MHz × multiplier / divider / post-divider, so this block only has to present the three fields in registers and mark each new set with a strobe.

All three lines are brought into the system clock domain through two-flop synchronisers. Rising edges of the latch and bit clock lines are then detected. A state machine walks through the fields: ST_IDLE waits for the first latch edge after reset, and ST_MUL, ST_DIV and ST_POST collect the multiplier, divider and post-divider bits. ST_DONE ignores the bit clock until the next latch edge. A latch rising edge in any state is the transition T_START, which enters ST_MUL with the bit counter and accumulator cleared. T_MUL_END moves ST_MUL to ST_DIV after the 7th bit. T_DIV_END moves ST_DIV to ST_POST after the 14th bit. T_COMMIT moves ST_POST to ST_DONE after the 16th bit. In all other cases the state holds. The serial bit clock must run at least four times slower than the system clock.

Top module: `pll_cfg_rx`

## Requirements
- R1: While reset is low and after it is released, mul_n, div_d and post_p are zero and cfg_update and cfg_invalid are low. This holds until the first complete frame.
- R2: Bit clock rising edges that arrive after reset but before the first latch rising edge are ignored. They produce no strobe and leave the outputs at zero.
- R3: A latch rising edge clears the bit counter and the accumulator. Bits of a frame that was cut short are discarded, and the outputs keep their previous values.
- R4: Data is sampled only on bit clock rising edges, most significant bit first. The first 7 bits after the latch edge form mul_n, and the first bit received becomes mul_n[6].
- R5: Bits 8 to 14 form div_d, with bit 8 as div_d[6]. Bits 15 and 16 form post_p, with bit 15 as post_p[1].
- R6: mul_n, div_d and post_p change only when the 16th bit completes. At that moment cfg_update is high for exactly one system clock cycle.
- R7: Bit clock edges after the 16th bit and before the next latch rising edge are ignored. They produce no strobe and cause no change to any output.
- R8: When a latch rising edge and a bit clock rising edge are detected in the same system cycle, the latch wins. That bit is discarded and the new frame starts empty.
- R9: A frame whose divider or post-divider is zero is still committed, and cfg_invalid rises together with its strobe. cfg_invalid then stays high until reset, even across later valid frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line (asynchronous) |
| ser_clk | input | 1 | Serial bit clock line (asynchronous) |
| ser_latch | input | 1 | Serial latch line; a rising edge starts a frame (asynchronous) |
| mul_n | output | 7 | Committed multiplier field |
| div_d | output | 7 | Committed divider field |
| post_p | output | 2 | Committed post-divider field |
| cfg_update | output | 1 | One-cycle strobe when a frame is committed |
| cfg_invalid | output | 1 | Sticky flag: a committed divider or post-divider was zero |

## Verification
A latch edge that restarts the frame can coincide in one system cycle with a bit clock edge that would shift a bit in. The bench provokes this mid-frame by raising both lines at the same instant while the data line is high. A full frame then follows. If the design had counted the colliding bit, that frame would commit one bit early with shifted fields. The scoreboard expects exactly the values of the follow-up frame and no other strobe, and an assertion confirms that the cycle after any latch edge has an empty counter.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_POST,
        ST_DONE
    } rx_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pll_cfg_sync.sv
// Multi-lane synchroniser chain into the system clock domain.
module pll_cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= raw_in;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pll_cfg_edge.sv
// Rising-edge detector on already synchronised levels.
module pll_cfg_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/pll_cfg_fsm.sv
// Frame state machine: counts bits, cuts fields, commits on the last bit.
module pll_cfg_fsm
    import pll_cfg_pkg::*;
#(
    parameter int MUL_W  = 7,
    parameter int DIV_W  = 7,
    parameter int POST_W = 2,
    localparam int FRAME_BITS = MUL_W + DIV_W + POST_W,
    localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_rise,
    input  logic              bit_rise,
    input  logic              ser_bit,
    output logic [MUL_W-1:0]  mul_n,
    output logic [DIV_W-1:0]  div_d,
    output logic [POST_W-1:0] post_p,
    output logic              cfg_update,
    output logic              cfg_invalid,
    output rx_state_e         state_q,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam int ACC_W = max3(MUL_W, DIV_W, POST_W);
    localparam logic [CNT_W-1:0] LAST_MUL = CNT_W'(MUL_W - 1);
    localparam logic [CNT_W-1:0] LAST_DIV = CNT_W'(MUL_W + DIV_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    rx_state_e        state_d;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] shifted;
    logic [MUL_W-1:0] pend_n;
    logic [DIV_W-1:0] pend_d;
    logic             collecting;

    assign shifted    = {acc_q[ACC_W-2:0], ser_bit};
    assign collecting = (state_q == ST_MUL) || (state_q == ST_DIV) || (state_q == ST_POST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (latch_rise) begin
            state_d = ST_MUL;                                  // T_START
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_MUL:  if (bit_rise && bit_cnt == LAST_MUL) state_d = ST_DIV;   // T_MUL_END
                ST_DIV:  if (bit_rise && bit_cnt == LAST_DIV) state_d = ST_POST;  // T_DIV_END
                ST_POST: if (bit_rise && bit_cnt == LAST_BIT) state_d = ST_DONE;  // T_COMMIT
                ST_DONE: state_d = ST_DONE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            acc_q       <= '0;
            pend_n      <= '0;
            pend_d      <= '0;
            mul_n       <= '0;
            div_d       <= '0;
            post_p      <= '0;
            cfg_update  <= 1'b0;
            cfg_invalid <= 1'b0;
        end else begin
            cfg_update <= 1'b0;
            if (latch_rise) begin
                bit_cnt <= '0;
                acc_q   <= '0;
            end else if (bit_rise && collecting) begin
                bit_cnt <= bit_cnt + 1'b1;
                acc_q   <= shifted;
                unique case (state_q)
                    ST_MUL: if (bit_cnt == LAST_MUL) begin
                        pend_n <= shifted[MUL_W-1:0];
                        acc_q  <= '0;
                    end
                    ST_DIV: if (bit_cnt == LAST_DIV) begin
                        pend_d <= shifted[DIV_W-1:0];
                        acc_q  <= '0;
                    end
                    ST_POST: if (bit_cnt == LAST_BIT) begin
                        mul_n      <= pend_n;
                        div_d      <= pend_d;
                        post_p     <= shifted[POST_W-1:0];
                        cfg_update <= 1'b1;
                        if (pend_d == '0 || shifted[POST_W-1:0] == '0)
                            cfg_invalid <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pll_cfg_rx.sv
// Top: passive receiver of synthesizer parameters from a shared serial bus.
module pll_cfg_rx #(
    parameter int MUL_W       = 7,
    parameter int DIV_W       = 7,
    parameter int POST_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_latch,
    output logic [MUL_W-1:0]  mul_n,
    output logic [DIV_W-1:0]  div_d,
    output logic [POST_W-1:0] post_p,
    output logic              cfg_update,
    output logic              cfg_invalid
);
    localparam int LANES = 3;
    localparam int CNT_W = $clog2(MUL_W + DIV_W + POST_W + 1);

    logic [LANES-1:0]        lane_lvl;
    logic [1:0]              lane_rise;
    logic                    latch_rise;
    logic                    bit_rise;
    pll_cfg_pkg::rx_state_e  state;
    logic [CNT_W-1:0]        bit_cnt;

    pll_cfg_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({ser_latch, ser_clk, ser_data}),
        .sync_out (lane_lvl)
    );

    pll_cfg_edge #(.WIDTH(2)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lane_lvl[2:1]),
        .rise  (lane_rise)
    );

    assign latch_rise = lane_rise[1];
    assign bit_rise   = lane_rise[0];

    pll_cfg_fsm #(.MUL_W(MUL_W), .DIV_W(DIV_W), .POST_W(POST_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_rise  (latch_rise),
        .bit_rise    (bit_rise),
        .ser_bit     (lane_lvl[0]),
        .mul_n       (mul_n),
        .div_d       (div_d),
        .post_p      (post_p),
        .cfg_update  (cfg_update),
        .cfg_invalid (cfg_invalid),
        .state_q     (state),
        .bit_cnt     (bit_cnt)
    );
endmodule

// File: rtl/pll_cfg_rx_chk.sv
module pll_cfg_rx_chk
    import pll_cfg_pkg::*;
#(
    parameter int MUL_W  = 7,
    parameter int DIV_W  = 7,
    parameter int POST_W = 2,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [MUL_W-1:0]  mul_n,
    input logic [DIV_W-1:0]  div_d,
    input logic [POST_W-1:0] post_p,
    input logic              cfg_update,
    input logic              cfg_invalid,
    input logic              latch_rise,
    input rx_state_e         state,
    input logic [CNT_W-1:0]  bit_cnt
);
    // R1: reset holds outputs cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (mul_n == '0 && div_d == '0 && post_p == '0 && !cfg_update && !cfg_invalid));

    // R6: strobe lasts a single cycle
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

    // R6: fields move only with the strobe
    p_fields_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_update |-> ($stable(mul_n) && $stable(div_d) && $stable(post_p)));

    // R2 and R7: no commit from waiting states without a new latch edge
    p_quiet_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE || state == ST_DONE) && !latch_rise) |=> !cfg_update);

    // R8, R3: a latch edge always leaves an empty frame
    p_latch_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rise |=> (bit_cnt == '0 && state == ST_MUL));

    // R9: invalid is sticky
    p_invalid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_invalid |=> cfg_invalid);

    // R9: invalid rises only on a commit with a zero divider field
    p_invalid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_invalid) |-> (cfg_update && (div_d == '0 || post_p == '0)));
endmodule

bind pll_cfg_rx pll_cfg_rx_chk #(
    .MUL_W(MUL_W), .DIV_W(DIV_W), .POST_W(POST_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mul_n       (mul_n),
    .div_d       (div_d),
    .post_p      (post_p),
    .cfg_update  (cfg_update),
    .cfg_invalid (cfg_invalid),
    .latch_rise  (latch_rise),
    .state       (state),
    .bit_cnt     (bit_cnt)
);

// File: tb/pll_cfg_rx_tb.sv
`timescale 1ns/1ps
module pll_cfg_rx_tb;
    localparam int HALF = 4;   // system clocks per half bit-clock period

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
    logic [6:0] mul_n, div_d;
    logic [1:0] post_p;
    logic       cfg_update, cfg_invalid;

    always #2.5 clk = ~clk;

    pll_cfg_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_latch(ser_latch), .mul_n(mul_n), .div_d(div_d), .post_p(post_p),
        .cfg_update(cfg_update), .cfg_invalid(cfg_invalid)
    );

    typedef struct packed { logic [6:0] n; logic [6:0] d; logic [1:0] p; logic inv; } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0, strobes = 0;
    logic model_inv = 1'b0;
    logic [6:0] last_n = '0, last_d = '0;
    logic [1:0] last_p = '0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_latch();
        ser_latch = 1'b1; wait_clks(HALF);
        ser_latch = 1'b0; wait_clks(HALF);
    endtask

    // send the top 'cnt' bits of word, MSB first
    task automatic send_bits(input logic [15:0] word, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            ser_data = word[15-i]; wait_clks(HALF);
            ser_clk  = 1'b1;       wait_clks(HALF);
            ser_clk  = 1'b0;
        end
        wait_clks(HALF);
    endtask

    task automatic expect_frame(input logic [6:0] n, input logic [6:0] d, input logic [1:0] p);
        if (d == 0 || p == 0) model_inv = 1'b1;
        exp_q.push_back('{n: n, d: d, p: p, inv: model_inv});
        last_n = n; last_d = d; last_p = p;
    endtask

    task automatic send_frame(input logic [6:0] n, input logic [6:0] d, input logic [1:0] p);
        expect_frame(n, d, p);
        pulse_latch();
        send_bits({n, d, p}, 16);
        wait_clks(8);
        chk(exp_q.size() == 0, "R6 frame committed", exp_q.size(), 0);
    endtask

    task automatic check_hold(input string tag);
        chk(mul_n == last_n, tag, mul_n, last_n);
        chk(div_d == last_d, tag, div_d, last_d);
        chk(post_p == last_p, tag, post_p, last_p);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_inv = 1'b0;
        last_n = '0; last_d = '0; last_p = '0;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(3);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && cfg_update === 1'b1) begin
            strobes++;
            if (exp_q.size() == 0) begin
                chk(0, "R6/R7 unexpected strobe", {mul_n, div_d, post_p}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({mul_n, div_d, post_p} == {e.n, e.d, e.p}, "R4/R5 fields",
                    {mul_n, div_d, post_p}, {e.n, e.d, e.p});
                chk(cfg_invalid == e.inv, "R9 invalid with strobe", cfg_invalid, e.inv);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog (all requirements)", 0, 1);
        finish_run();
    end

    initial begin
        int s0;
        rst_n = 1'b0;
        wait_clks(3);
        // R1: during reset
        chk({mul_n, div_d, post_p, cfg_update, cfg_invalid} == 0, "R1 in reset",
            {mul_n, div_d, post_p, cfg_update, cfg_invalid}, 0);
        rst_n = 1'b1;
        wait_clks(3);
        chk({mul_n, div_d, post_p, cfg_update, cfg_invalid} == 0, "R1 after release",
            {mul_n, div_d, post_p, cfg_update, cfg_invalid}, 0);

        // R2: bit clock before any latch edge
        send_bits(16'hFFFF, 16);
        wait_clks(8);
        chk(strobes == 0, "R2 no strobe before latch", strobes, 0);
        check_hold("R2 outputs stay zero");

        // R4/R5: distinct patterns
        send_frame(7'h55, 7'h2A, 2'b10);
        send_frame(7'h7F, 7'h01, 2'b01);
        send_frame(7'h01, 7'h40, 2'b11);
        chk(cfg_invalid == 1'b0, "R9 valid frames keep invalid low", cfg_invalid, 0);

        // R6: nothing changes before the 16th bit
        s0 = strobes;
        pulse_latch();
        send_bits({7'h33, 7'h4C, 2'b01}, 15);
        chk(strobes == s0, "R6 no strobe after 15 bits", strobes, s0);
        check_hold("R6 fields held before last bit");
        expect_frame(7'h33, 7'h4C, 2'b01);
        send_bits({15'h0, 1'b1} << 15, 1);   // 16th bit = 1
        wait_clks(8);
        chk(exp_q.size() == 0, "R6 commit on 16th bit", exp_q.size(), 0);

        // R7: extra edges after the 16th bit
        s0 = strobes;
        send_bits(16'h0000, 6);
        wait_clks(8);
        chk(strobes == s0, "R7 no strobe from trailing edges", strobes, s0);
        check_hold("R7 fields unchanged");

        // R3: truncated frame discarded, restart
        s0 = strobes;
        pulse_latch();
        send_bits({7'h12, 7'h34, 2'b11}, 9);
        chk(strobes == s0, "R3 partial frame no strobe", strobes, s0);
        check_hold("R3 partial frame no change");
        send_frame(7'h6E, 7'h15, 2'b10);

        // R8: latch and bit clock rise together
        pulse_latch();
        send_bits({7'h7F, 7'h7F, 2'b11}, 5);
        ser_data = 1'b1; wait_clks(HALF);
        ser_latch = 1'b1; ser_clk = 1'b1; wait_clks(HALF);
        ser_latch = 1'b0; ser_clk = 1'b0; wait_clks(HALF);
        expect_frame(7'h0A, 7'h2B, 2'b01);
        send_bits({7'h0A, 7'h2B, 2'b01}, 16);
        wait_clks(8);
        chk(exp_q.size() == 0, "R8 collision frame committed", exp_q.size(), 0);
        check_hold("R8 collision bit dropped");

        // R9: zero divider, then sticky across valid frame
        send_frame(7'h20, 7'h00, 2'b01);
        chk(cfg_invalid == 1'b1, "R9 zero divider flags", cfg_invalid, 1);
        check_hold("R9 zero divider still captured");
        send_frame(7'h21, 7'h05, 2'b10);
        chk(cfg_invalid == 1'b1, "R9 flag sticky", cfg_invalid, 1);

        // R1: reset clears; R9: zero post-divider
        do_reset();
        chk({mul_n, div_d, post_p, cfg_invalid} == 0, "R1 reset clears",
            {mul_n, div_d, post_p, cfg_invalid}, 0);
        send_frame(7'h11, 7'h22, 2'b00);
        chk(cfg_invalid == 1'b1, "R9 zero post-divider flags", cfg_invalid, 1);

        wait_clks(10);
        finish_run();
    end
endmodule